// File: doc/BRIEF.md
# XOR Work Descriptor Field Parser

This block sits between the fetch logic of an XOR/RAID offload engine and its execution datapath. A 128-byte work descriptor arrives as 32 back-to-back 32-bit words on a valid/ready input stream. The parser counts the words and captures each field as its word arrives. It rebuilds the 48-bit data-buffer addresses, whose low and high parts are spread over triplets of words. After the final word it releases one decoded command on a valid/ready output.

The decoded command carries the software tag, the status flags, the operation mode, the done-notification and result-buffer enables, the active buffer count, the byte count, the source or fill address, the destination address and every data-buffer address. Before a command is released it is checked for legality. An undefined mode, or an XOR whose active-buffer count is outside 1..MAX_BUFS, raises a one-cycle error pulse instead, and no command is issued. While a command waits for the consumer, the input stream is stalled.

Top module: `xor_desc_parser`

## Requirements
- R1: After reset, cmdValid and errPulse are 0 and inReady is 1.
- R2: cmdSwId is bits [15:0] of word 0, cmdFlags is bits [31:16] of word 0, and cmdByteCount is word 3 (words numbered 0..31 in arrival order).
- R3: The control word (word 2) decodes as follows: cmdMode = [31:28], cmdNotify = bit 27, cmdBufCount = [26:22], cmdPEn = bit 17, cmdQEn = bit 16.
- R4: cmdSrcAddr is {word 5 [15:0], word 4}. cmdDstAddr is {word 7 [15:0], word 6}.
- R5: For pair k (0..3), the low 32 bits of buffer 2k are word 8+3k and the low 32 bits of buffer 2k+1 are word 9+3k. Word 10+3k supplies the high 16 bits of buffer 2k in [15:0] and of buffer 2k+1 in [31:16]. Buffer i is cmdBufAddr[48i+47:48i].
- R6: A result (cmdValid or errPulse) appears only in the cycle after the 32nd word of a descriptor is accepted, never earlier. The word count then restarts at 0.
- R7: While cmdValid is 1 and cmdReady is 0, cmdValid stays 1, all command outputs hold, and inReady is 0. One cycle after cmdValid and cmdReady are both 1, cmdValid is 0 and inReady is 1.
- R8: A mode value above 8 gives a one-cycle errPulse and no cmdValid. Modes 0..8 are defined.
- R9: Mode 6 (XOR) with cmdBufCount 0 or above MAX_BUFS gives errPulse and no command. XOR with a count of 1..MAX_BUFS, and any other defined mode with any count, issues a command.
- R10: Word 1 and words 20..31 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Descriptor word present |
| inData | input | 32 | Descriptor word |
| inReady | output | 1 | Parser accepts a word this cycle |
| cmdValid | output | 1 | Decoded command available |
| cmdReady | input | 1 | Consumer takes the command |
| errPulse | output | 1 | One-cycle pulse: illegal descriptor dropped |
| cmdSwId | output | 16 | Software tag |
| cmdFlags | output | 16 | Status flags |
| cmdMode | output | 4 | Operation mode |
| cmdNotify | output | 1 | Notify-on-done request |
| cmdPEn | output | 1 | P result buffer enable |
| cmdQEn | output | 1 | Q result buffer enable |
| cmdBufCount | output | 5 | Active data buffer count |
| cmdByteCount | output | 32 | Byte count |
| cmdSrcAddr | output | 48 | Source or fill address |
| cmdDstAddr | output | 48 | Destination address |
| cmdBufAddr | output | 384 | MAX_BUFS 48-bit data-buffer addresses |

## Verification
The bench aims at the XOR count boundaries 0, 1, 8 and 9, at mode 8 against modes 9 and 15, and at a copy command with a zero count. A legality check that is off by one would issue a bad command or drop a good one. It drives distinct random high halves into every pair-shared word, so swapped halves or a wrong triplet offset show up as corrupted buffer addresses. Random junk in word 1 and the reserved tail catches decoders that let those words overwrite captured fields. Consumer stalls check that the fields hold and that input is refused, which a parser that kept accepting words would violate.

// File: rtl/xor_desc_pkg.sv
package xor_desc_pkg;
  localparam int DESC_WORDS = 32;
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam int ADDR_W = 48;
  localparam int HI_W = ADDR_W - 32;

  localparam int W_TAG = 0;
  localparam int W_CTRL = 2;
  localparam int W_LEN = 3;
  localparam int W_SRC_LO = 4;
  localparam int W_SRC_HI = 5;
  localparam int W_DST_LO = 6;
  localparam int W_DST_HI = 7;
  localparam int W_BUF_BASE = 8;

  localparam int MODE_MSB = 31;
  localparam int MODE_LSB = 28;
  localparam int NOTIFY_BIT = 27;
  localparam int CNT_MSB = 26;
  localparam int CNT_LSB = 22;
  localparam int PEN_BIT = 17;
  localparam int QEN_BIT = 16;
  localparam int CNT_W = CNT_MSB - CNT_LSB + 1;

  localparam logic [3:0] MODE_XOR = 4'd6;
  localparam logic [3:0] MODE_LAST = 4'd8;

  typedef struct packed {
    logic capture;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/xor_desc_ctrl.sv
module xor_desc_ctrl
  import xor_desc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  input  logic    cmdReady,
  output logic    cmdValid,
  output logic    errPulse,
  input  logic    illegal,
  output strobe_t stb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  logic [IDX_W-1:0] wordIdx;
  logic holding;
  logic accept;
  logic lastWord;

  assign inReady = !holding;
  assign accept = inValid && inReady;
  assign lastWord = accept && (wordIdx == LAST_IDX);
  assign cmdValid = holding;
  assign stb.capture = accept;
  assign stb.idx = wordIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
      holding <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= lastWord && illegal;
      if (accept) wordIdx <= lastWord ? '0 : wordIdx + 1'b1;
      if (lastWord && !illegal) holding <= 1'b1;
      else if (holding && cmdReady) holding <= 1'b0;
    end
  end
endmodule

// File: rtl/xor_desc_datapath.sv
module xor_desc_datapath
  import xor_desc_pkg::*;
#(
  parameter int MAX_BUFS = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [31:0]                inData,
  output logic [15:0]                cmdSwId,
  output logic [15:0]                cmdFlags,
  output logic [3:0]                 cmdMode,
  output logic                       cmdNotify,
  output logic                       cmdPEn,
  output logic                       cmdQEn,
  output logic [CNT_W-1:0]           cmdBufCount,
  output logic [31:0]                cmdByteCount,
  output logic [ADDR_W-1:0]          cmdSrcAddr,
  output logic [ADDR_W-1:0]          cmdDstAddr,
  output logic [MAX_BUFS*ADDR_W-1:0] cmdBufAddr,
  output logic                       illegal
);
  localparam int NUM_PAIRS = MAX_BUFS / 2;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BUFS);

  logic [31:0] ctrlWord;

  function automatic logic hit(input strobe_t s, input int w);
    return s.capture && (s.idx == IDX_W'(w));
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSwId <= '0;
      cmdFlags <= '0;
      ctrlWord <= '0;
      cmdByteCount <= '0;
      cmdSrcAddr <= '0;
      cmdDstAddr <= '0;
    end else begin
      if (hit(stb, W_TAG)) begin
        cmdSwId <= inData[15:0];
        cmdFlags <= inData[31:16];
      end
      if (hit(stb, W_CTRL)) ctrlWord <= inData;
      if (hit(stb, W_LEN)) cmdByteCount <= inData;
      if (hit(stb, W_SRC_LO)) cmdSrcAddr[31:0] <= inData;
      if (hit(stb, W_SRC_HI)) cmdSrcAddr[ADDR_W-1:32] <= inData[HI_W-1:0];
      if (hit(stb, W_DST_LO)) cmdDstAddr[31:0] <= inData;
      if (hit(stb, W_DST_HI)) cmdDstAddr[ADDR_W-1:32] <= inData[HI_W-1:0];
    end
  end

  assign cmdMode = ctrlWord[MODE_MSB:MODE_LSB];
  assign cmdNotify = ctrlWord[NOTIFY_BIT];
  assign cmdBufCount = ctrlWord[CNT_MSB:CNT_LSB];
  assign cmdPEn = ctrlWord[PEN_BIT];
  assign cmdQEn = ctrlWord[QEN_BIT];

  assign illegal = (cmdMode > MODE_LAST) ||
                   ((cmdMode == MODE_XOR) &&
                    ((cmdBufCount == '0) || (cmdBufCount > CNT_MAX)));

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : gPair
    localparam int BASE = W_BUF_BASE + 3 * k;
    logic [31:0] loEven;
    logic [31:0] loOdd;
    logic [HI_W-1:0] hiEven;
    logic [HI_W-1:0] hiOdd;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loEven <= '0;
        loOdd <= '0;
        hiEven <= '0;
        hiOdd <= '0;
      end else begin
        if (hit(stb, BASE)) loEven <= inData;
        if (hit(stb, BASE + 1)) loOdd <= inData;
        if (hit(stb, BASE + 2)) begin
          hiEven <= inData[15:0];
          hiOdd <= inData[31:16];
        end
      end
    end

    assign cmdBufAddr[(2*k)*ADDR_W +: ADDR_W] = {hiEven, loEven};
    assign cmdBufAddr[(2*k+1)*ADDR_W +: ADDR_W] = {hiOdd, loOdd};
  end
endmodule

// File: rtl/xor_desc_parser.sv
module xor_desc_parser
  import xor_desc_pkg::*;
#(
  parameter int MAX_BUFS = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [31:0]                inData,
  output logic                       inReady,
  output logic                       cmdValid,
  input  logic                       cmdReady,
  output logic                       errPulse,
  output logic [15:0]                cmdSwId,
  output logic [15:0]                cmdFlags,
  output logic [3:0]                 cmdMode,
  output logic                       cmdNotify,
  output logic                       cmdPEn,
  output logic                       cmdQEn,
  output logic [4:0]                 cmdBufCount,
  output logic [31:0]                cmdByteCount,
  output logic [47:0]                cmdSrcAddr,
  output logic [47:0]                cmdDstAddr,
  output logic [MAX_BUFS*48-1:0]     cmdBufAddr
);
  strobe_t stb;
  logic illegal;

  xor_desc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .cmdReady(cmdReady), .cmdValid(cmdValid), .errPulse(errPulse),
    .illegal(illegal), .stb(stb)
  );

  xor_desc_datapath #(.MAX_BUFS(MAX_BUFS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .cmdSwId(cmdSwId), .cmdFlags(cmdFlags), .cmdMode(cmdMode),
    .cmdNotify(cmdNotify), .cmdPEn(cmdPEn), .cmdQEn(cmdQEn),
    .cmdBufCount(cmdBufCount), .cmdByteCount(cmdByteCount),
    .cmdSrcAddr(cmdSrcAddr), .cmdDstAddr(cmdDstAddr),
    .cmdBufAddr(cmdBufAddr), .illegal(illegal)
  );
endmodule

// File: rtl/xor_desc_parser_chk.sv
module xor_desc_parser_chk #(
  parameter int MAX_BUFS = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   inReady,
  input logic                   cmdValid,
  input logic                   cmdReady,
  input logic                   errPulse,
  input logic [3:0]             cmdMode,
  input logic [4:0]             cmdBufCount,
  input logic [31:0]            cmdByteCount,
  input logic [47:0]            cmdSrcAddr,
  input logic [MAX_BUFS*48-1:0] cmdBufAddr
);
  logic [4:0] seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= '0;
    else if (inValid && inReady) seen <= seen + 1'b1;
  end

  assert_result_after_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cmdValid) || errPulse) |-> (seen == 5'd0) && $past(inValid && inReady));

  assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> cmdValid && $stable(cmdByteCount) &&
      $stable(cmdSrcAddr) && $stable(cmdBufAddr) && $stable(cmdMode));

  assert_no_input_while_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !inReady);

  assert_error_excludes_cmd_R8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !cmdValid && ((cmdMode > 4'd8) ||
      ((cmdMode == 4'd6) && ((cmdBufCount == 5'd0) || (cmdBufCount > 5'(MAX_BUFS))))));

  assert_xor_count_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdMode == 4'd6) |->
      (cmdBufCount != 5'd0) && (cmdBufCount <= 5'(MAX_BUFS)));

  assert_mode_defined_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdMode <= 4'd8);
endmodule

bind xor_desc_parser xor_desc_parser_chk #(.MAX_BUFS(MAX_BUFS)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .errPulse(errPulse),
  .cmdMode(cmdMode), .cmdBufCount(cmdBufCount), .cmdByteCount(cmdByteCount),
  .cmdSrcAddr(cmdSrcAddr), .cmdBufAddr(cmdBufAddr)
);

// File: tb/tb_xor_desc_parser.sv
module tb_xor_desc_parser;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inData = '0;
  logic cmdReady = 1'b0;
  logic inReady, cmdValid, errPulse;
  logic [15:0] cmdSwId, cmdFlags;
  logic [3:0] cmdMode;
  logic cmdNotify, cmdPEn, cmdQEn;
  logic [4:0] cmdBufCount;
  logic [31:0] cmdByteCount;
  logic [47:0] cmdSrcAddr, cmdDstAddr;
  logic [NB*48-1:0] cmdBufAddr;

  int tests = 0;
  int fails = 0;

  logic [15:0] eTag, eFlg;
  logic [3:0] eMode;
  logic eNot, eP, eQ;
  logic [4:0] eCnt;
  logic [31:0] eLen;
  logic [47:0] eSrc, eDst;
  logic [47:0] eBuf [NB];
  logic [31:0] w [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  xor_desc_parser #(.MAX_BUFS(NB)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .errPulse(errPulse),
    .cmdSwId(cmdSwId), .cmdFlags(cmdFlags), .cmdMode(cmdMode), .cmdNotify(cmdNotify),
    .cmdPEn(cmdPEn), .cmdQEn(cmdQEn), .cmdBufCount(cmdBufCount),
    .cmdByteCount(cmdByteCount), .cmdSrcAddr(cmdSrcAddr), .cmdDstAddr(cmdDstAddr),
    .cmdBufAddr(cmdBufAddr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expLegal();
    if (eMode > 4'd8) return 1'b0;
    if (eMode == 4'd6 && (eCnt == 5'd0 || eCnt > 5'(NB))) return 1'b0;
    return 1'b1;
  endfunction

  task automatic randFields(input logic [3:0] mode, input logic [4:0] cnt);
    eTag = 16'($urandom); eFlg = 16'($urandom);
    eMode = mode; eCnt = cnt;
    eNot = 1'($urandom); eP = 1'($urandom); eQ = 1'($urandom);
    eLen = $urandom;
    eSrc = {16'($urandom), $urandom}; eDst = {16'($urandom), $urandom};
    for (int i = 0; i < NB; i++) eBuf[i] = {16'($urandom), $urandom};
  endtask

  task automatic packWords();
    w[0] = {eFlg, eTag};
    w[1] = $urandom;
    w[2] = {eMode, eNot, eCnt, 4'($urandom), eP, eQ, 16'($urandom)};
    w[3] = eLen;
    w[4] = eSrc[31:0]; w[5] = {16'($urandom), eSrc[47:32]};
    w[6] = eDst[31:0]; w[7] = {16'($urandom), eDst[47:32]};
    for (int k = 0; k < NB/2; k++) begin
      w[8+3*k] = eBuf[2*k][31:0];
      w[9+3*k] = eBuf[2*k+1][31:0];
      w[10+3*k] = {eBuf[2*k+1][47:32], eBuf[2*k][47:32]};
    end
    for (int i = 20; i < 32; i++) w[i] = $urandom;
  endtask

  task automatic checkFields(input string tag);
    check({"R2 tag ", tag}, 64'(cmdSwId), 64'(eTag));
    check({"R2 flags ", tag}, 64'(cmdFlags), 64'(eFlg));
    check({"R2 len ", tag}, 64'(cmdByteCount), 64'(eLen));
    check({"R3 ctrl ", tag}, 64'({cmdMode, cmdNotify, cmdBufCount, cmdPEn, cmdQEn}),
          64'({eMode, eNot, eCnt, eP, eQ}));
    check({"R4 src ", tag}, 64'(cmdSrcAddr), 64'(eSrc));
    check({"R4 dst ", tag}, 64'(cmdDstAddr), 64'(eDst));
    for (int i = 0; i < NB; i++)
      check({"R5 buf ", tag}, 64'(cmdBufAddr[i*48 +: 48]), 64'(eBuf[i]));
  endtask

  task automatic runDesc(input string tag, input int stall);
    logic early;
    logic legal;
    packWords();
    legal = expLegal();
    early = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (i > 0 && (cmdValid || errPulse || !inReady)) early = 1'b1;
      inValid = 1'b1;
      inData = w[i];
    end
    @(negedge clk);
    inValid = 1'b0;
    check({"R6 no early result ", tag}, 64'(early), 64'd0);
    check({"R8 R9 cmdValid ", tag}, 64'(cmdValid), 64'(legal));
    check({"R8 R9 errPulse ", tag}, 64'(errPulse), 64'(!legal));
    if (legal) begin
      checkFields(tag);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check({"R7 held ", tag}, 64'({cmdValid, inReady}), 64'b10);
      end
      checkFields({tag, " after stall R7 R10"});
      cmdReady = 1'b1;
      @(negedge clk);
      cmdReady = 1'b0;
      check({"R7 released ", tag}, 64'({cmdValid, inReady}), 64'b01);
    end else begin
      @(negedge clk);
      check({"R8 pulse one cycle ", tag}, 64'({errPulse, cmdValid, inReady}), 64'b001);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd7713));
    repeat (3) @(negedge clk);
    check("R1 reset", 64'({cmdValid, errPulse, inReady}), 64'b001);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 64'({cmdValid, errPulse, inReady}), 64'b001);

    randFields(4'd6, 5'd1);  runDesc("xor cnt1 R9", 2);
    randFields(4'd6, 5'd8);  runDesc("xor cnt8 R9", 0);
    randFields(4'd6, 5'd0);  runDesc("xor cnt0 R9", 0);
    randFields(4'd6, 5'd9);  runDesc("xor cnt9 R9", 0);
    randFields(4'd8, 5'd0);  runDesc("mode8 R8", 1);
    randFields(4'd9, 5'd3);  runDesc("mode9 R8", 0);
    randFields(4'd15, 5'd2); runDesc("mode15 R8", 0);
    randFields(4'd1, 5'd0);  runDesc("copy cnt0 R9", 3);
    randFields(4'd6, 5'd4);  runDesc("xor R10 a", 0);
    runDesc("xor R10 b same fields new junk", 0);

    for (int n = 0; n < 40; n++) begin
      randFields(4'($urandom), 5'($urandom));
      runDesc("random", int'($urandom % 4));
    end
    finishRun();
  end
endmodule